// File: doc/BRIEF.md
# Complementary PWM Timer with Dead-Time Insertion

This block drives the six gates of a three-phase bridge. A 16-bit counter, fed by a programmable clock divider, runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each of the three phase channels compares the count with its own compare value to form a reference level. That level becomes a high-side output and a low-side output. Whenever the two switch over, both outputs are held low for a programmable number of divided clock periods. A one-shot option runs the counter through a single period and then parks it. A debug-halt input stops the counter and turns every switch off while it is asserted.

The counter controller has four states. CNT_IDLE is held while `enable` is low. CNT_UP counts upward. CNT_DOWN counts downward and is used only in center mode. CNT_DONE parks the counter after a one-shot period. The transitions are as follows:
- idle-start: CNT_IDLE to CNT_UP.
- wrap: CNT_UP to CNT_UP, an update event.
- peak: CNT_UP to CNT_DOWN.
- valley: CNT_DOWN to CNT_UP, an update event.
- shot-end: CNT_UP or CNT_DOWN to CNT_DONE.
- disable: any state to CNT_IDLE.

Each channel has its own five-state output sequencer. DT_OFF has both outputs low. DT_GAP_HI and DT_GAP_LO are the dead-time waits. DT_HI and DT_LO drive one side each. Its transitions are:
- resume: DT_OFF to a gap state.
- fall: DT_HI to DT_GAP_LO.
- rise: DT_LO to DT_GAP_HI.
- settle: a gap state to its target.
- abort: a gap state back to the side it came from, when the reference reverts.
- force-off: any state to DT_OFF.

Top module: `cpwm_deadtime`

## Requirements
- R1: With divider value P in `psc_div`, the counter advances once every P+1 clock cycles, and all durations below are in these divided periods.
- R2: In edge-aligned mode (`center_mode`=0) the count runs 0,1,…,reload and wraps to 0, giving a period of reload+1 divided periods.
- R3: In center-aligned mode (`center_mode`=1, reload ≥ 1) the count runs up to reload and back down to 0. The period is 2×reload divided periods, in which the value 0 and the value reload each occur once.
- R4: A channel's reference is high while count < compare. A compare of 0 keeps the high-side output low and the low-side output high in steady state. A compare greater than reload keeps the high-side output high and the low-side output low.
- R5: At each switch-over both outputs of a pair stay low for `dead_time` divided periods. In steady state the high side is on for (H − D) periods per cycle, where H is the number of reference-high periods and D is the dead time. The low side is on for (period − H − D) periods. A dead time of 0 switches the two sides over directly.
- R6: The high-side and low-side outputs of one channel are never high in the same cycle.
- R7: With `one_pulse`=1 the counter runs exactly one period and then stops with count 0. All outputs stay low until `enable` is dropped.
- R8: While `dbg_halt` is high, the count and the divider hold their values and all six outputs are low in that same cycle.
- R9: The reload and compare inputs are copied into working registers only at an update event (the edge-mode wrap or the center-mode valley) and continuously while `enable` is low. A reload written mid-period does not change the current period.
- R10: Dropping `enable` returns the count to 0 and drives all six outputs low within two clock cycles.
- R11: During and after reset the count is 0 and all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the counter; low returns it to idle |
| center_mode | input | 1 | 1 selects the up/down triangle count |
| one_pulse | input | 1 | 1 stops the counter after one period |
| dbg_halt | input | 1 | Freeze the counter and force all outputs low |
| psc_div | input | 16 | Clock divider value P (advance every P+1 cycles) |
| reload | input | 16 | Period limit, taken at the update event |
| compare | input | 48 | Three 16-bit compare values, channel 0 in bits 15:0 |
| dead_time | input | 8 | Dead-time length in divided periods |
| pwm_hi | output | 3 | High-side gate per channel |
| pwm_lo | output | 3 | Low-side gate per channel |
| count | output | 16 | Current counter value |

## Verification
The hardest situation to produce is the steady periodic pattern with its exact on-times. The gap states are entered only a cycle after the counter moves, so the first period after start-up is always irregular. The bench therefore lets each configuration run for several whole periods before it counts high-side and low-side cycles over exactly one period. It compares those counts with the dead-time arithmetic of R5, in both counting modes and with the divider above 1. The mid-period reload write for R9 is timed by watching the count port and writing just after it passes 3. The bench then checks that the old limit still ends the current period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        CNT_IDLE,
        CNT_UP,
        CNT_DOWN,
        CNT_DONE
    } cnt_state_t;

    typedef enum logic [2:0] {
        DT_OFF,
        DT_GAP_HI,
        DT_HI,
        DT_GAP_LO,
        DT_LO
    } dt_state_t;

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             hold,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pcnt <= '0;
        else if (!active)       pcnt <= '0;
        else if (!hold) begin
            if (pcnt >= div)    pcnt <= '0;
            else                pcnt <= pcnt + 1'b1;
        end
    end

    assign tick = active && !hold && (pcnt >= div);

    // R8: the divider keeps its phase while frozen
    p_psc_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && active) |=> $stable(pcnt));

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 center_mode,
    input  logic                 one_pulse,
    input  logic                 halt,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     reload_in,
    input  logic [NCH*CNT_W-1:0] cmp_in,
    output logic [CNT_W-1:0]     cnt,
    output logic [NCH*CNT_W-1:0] cmp_act,
    output logic                 running,
    output logic                 strobe
);
    cnt_state_t       state, nstate;
    logic [CNT_W-1:0] ncnt;
    logic [CNT_W-1:0] arr_q;
    logic             upd;
    logic             start;

    // next state and next count
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        upd    = 1'b0;
        unique case (state)
            CNT_IDLE: begin
                ncnt = '0;
                if (enable && !halt) nstate = CNT_UP;
            end
            CNT_UP: begin
                if (tick) begin
                    if (cnt >= arr_q) begin
                        if (center_mode && arr_q != '0) begin
                            nstate = CNT_DOWN;
                            ncnt   = arr_q - 1'b1;
                        end else begin
                            ncnt = '0;
                            upd  = 1'b1;
                            if (one_pulse) nstate = CNT_DONE;
                        end
                    end else begin
                        ncnt = cnt + 1'b1;
                    end
                end
            end
            CNT_DOWN: begin
                if (tick) begin
                    if (cnt == '0) begin
                        upd = 1'b1;
                        if (one_pulse) begin
                            nstate = CNT_DONE;
                        end else begin
                            nstate = CNT_UP;
                            // a zero limit arriving at the valley parks at 0
                            ncnt = (reload_in != '0) ? CNT_W'(1) : '0;
                        end
                    end else begin
                        ncnt = cnt - 1'b1;
                    end
                end
            end
            CNT_DONE: ncnt = '0;
            default:  nstate = CNT_IDLE;
        endcase
        if (!enable) begin
            nstate = CNT_IDLE;
            ncnt   = '0;
        end
    end

    assign start = (state == CNT_IDLE) && enable && !halt;

    // state register, count and working copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CNT_IDLE;
            cnt     <= '0;
            arr_q   <= '0;
            cmp_act <= '0;
            strobe  <= 1'b0;
        end else begin
            state  <= nstate;
            cnt    <= ncnt;
            strobe <= tick || start;
            if (state == CNT_IDLE || upd) begin
                arr_q   <= reload_in;
                cmp_act <= cmp_in;
            end
        end
    end

    // outputs
    always_comb begin
        running = (state == CNT_UP) || (state == CNT_DOWN);
    end

    // R2: a running count never passes the working limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= arr_q));
    // R8: halt freezes the count
    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && enable) |=> $stable(cnt));
    // R7: a finished one-shot stays parked at zero
    p_shot_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_DONE && enable) |=> (state == CNT_DONE && cnt == '0));
    // R9: the working limit only moves at an update event
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CNT_IDLE && !upd) |=> $stable(arr_q));

endmodule

// File: rtl/cpwm_dtgen.sv
module cpwm_dtgen
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             halt,
    input  logic             strobe,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dead,
    output logic             hi,
    output logic             lo
);
    dt_state_t       st, nst;
    logic [DT_W-1:0] dt, ndt;
    logic            ref_hi;

    assign ref_hi = (cnt < cmp);

    always_comb begin
        nst = st;
        ndt = dt;
        if (!running || halt) begin
            nst = DT_OFF;
        end else if (strobe) begin
            unique case (st)
                DT_OFF: begin
                    ndt = dead;
                    if (dead == '0) nst = ref_hi ? DT_HI : DT_LO;
                    else            nst = ref_hi ? DT_GAP_HI : DT_GAP_LO;
                end
                DT_GAP_HI: begin
                    if (!ref_hi)       nst = DT_LO;
                    else if (dt <= 1)  nst = DT_HI;
                    else               ndt = dt - 1'b1;
                end
                DT_GAP_LO: begin
                    if (ref_hi)        nst = DT_HI;
                    else if (dt <= 1)  nst = DT_LO;
                    else               ndt = dt - 1'b1;
                end
                DT_HI: begin
                    if (!ref_hi) begin
                        ndt = dead;
                        nst = (dead == '0) ? DT_LO : DT_GAP_LO;
                    end
                end
                DT_LO: begin
                    if (ref_hi) begin
                        ndt = dead;
                        nst = (dead == '0) ? DT_HI : DT_GAP_HI;
                    end
                end
                default: nst = DT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= DT_OFF;
            dt <= '0;
        end else begin
            st <= nst;
            dt <= ndt;
        end
    end

    always_comb begin
        hi = (st == DT_HI) && !halt;
        lo = (st == DT_LO) && !halt;
    end

    // R6: a pair never conducts on both sides
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));
    // R5: with a nonzero gap the high side never turns on straight after the low side
    p_gap_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead != '0 && $rose(hi)) |-> !$past(lo));
    // R8: halt sends the sequencer to its off state
    p_halt_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st == DT_OFF));

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 center_mode,
    input  logic                 one_pulse,
    input  logic                 dbg_halt,
    input  logic [CNT_W-1:0]     psc_div,
    input  logic [CNT_W-1:0]     reload,
    input  logic [NCH*CNT_W-1:0] compare,
    input  logic [DT_W-1:0]      dead_time,
    output logic [NCH-1:0]       pwm_hi,
    output logic [NCH-1:0]       pwm_lo,
    output logic [CNT_W-1:0]     count
);
    logic                 tick;
    logic                 running;
    logic                 strobe;
    logic [NCH*CNT_W-1:0] cmp_act;

    cpwm_prescaler #(.PSC_W(CNT_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (running),
        .hold   (dbg_halt),
        .div    (psc_div),
        .tick   (tick)
    );

    cpwm_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .center_mode (center_mode),
        .one_pulse   (one_pulse),
        .halt        (dbg_halt),
        .tick        (tick),
        .reload_in   (reload),
        .cmp_in      (compare),
        .cnt         (count),
        .cmp_act     (cmp_act),
        .running     (running),
        .strobe      (strobe)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpwm_dtgen #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .running (running),
            .halt    (dbg_halt),
            .strobe  (strobe),
            .cnt     (count),
            .cmp     (cmp_act[g*CNT_W +: CNT_W]),
            .dead    (dead_time),
            .hi      (pwm_hi[g]),
            .lo      (pwm_lo[g])
        );
    end

    // R8: every gate is off while halted
    p_halt_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halt |-> (pwm_hi == '0 && pwm_lo == '0));

endmodule

// File: tb/cpwm_deadtime_tb.sv
`timescale 1ns/1ps
module cpwm_deadtime_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        center_mode = 1'b0;
    logic        one_pulse = 1'b0;
    logic        dbg_halt = 1'b0;
    logic [15:0] psc_div = '0;
    logic [15:0] reload = '0;
    logic [47:0] compare = '0;
    logic [7:0]  dead_time = '0;
    logic [2:0]  pwm_hi, pwm_lo;
    logic [15:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int hc[3];
    int lc[3];
    int ovl;

    always #2 clk = ~clk;

    cpwm_deadtime u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
        .one_pulse(one_pulse), .dbg_halt(dbg_halt), .psc_div(psc_div),
        .reload(reload), .compare(compare), .dead_time(dead_time),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .count(count)
    );

    // vectors: center, reload, compare ch0, dead, expected hi/lo for ch0, period
    localparam int NV = 8;
    localparam int V_CEN[NV] = '{0, 0, 0, 0, 1, 1, 1, 0};
    localparam int V_ARR[NV] = '{9, 9, 9, 9, 8, 8, 8, 15};
    localparam int V_CMP[NV] = '{4, 0, 10, 4, 3, 0, 9, 8};
    localparam int V_DT [NV] = '{2, 2, 2, 0, 1, 3, 3, 5};
    localparam int V_HI [NV] = '{2, 0, 10, 4, 4, 0, 16, 3};
    localparam int V_LO [NV] = '{4, 10, 0, 6, 10, 16, 0, 3};
    localparam int V_PER[NV] = '{10, 10, 10, 10, 16, 16, 16, 16};

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ch1 always gets compare 0, ch2 gets reload+1
    task automatic setup(input int cen, input int op, input int psc,
                         input int arr, input int c0, input int d);
        @(negedge clk);
        enable      = 1'b0;
        center_mode = cen[0];
        one_pulse   = op[0];
        psc_div     = 16'(psc);
        reload      = 16'(arr);
        compare     = {16'(arr + 1), 16'd0, 16'(c0)};
        dead_time   = 8'(d);
        repeat (3) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic measure(input int n);
        for (int c = 0; c < 3; c++) begin hc[c] = 0; lc[c] = 0; end
        ovl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < 3; c++) begin
                if (pwm_hi[c]) hc[c]++;
                if (pwm_lo[c]) lc[c]++;
                if (pwm_hi[c] && pwm_lo[c]) ovl++;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0, z, mv, mx, tr;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 count in reset", int'(count), 0);
        chk("R11 outputs in reset", int'({pwm_hi, pwm_lo}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 outputs after reset", int'({pwm_hi, pwm_lo}), 0);

        // R2 R3 R4 R5 R6: vector table in both modes
        for (int v = 0; v < NV; v++) begin
            setup(V_CEN[v], 0, 0, V_ARR[v], V_CMP[v], V_DT[v]);
            repeat (4 * V_PER[v]) @(negedge clk);
            measure(V_PER[v]);
            chk($sformatf("R5 vec%0d ch0 hi", v), hc[0], V_HI[v]);
            chk($sformatf("R5 vec%0d ch0 lo", v), lc[0], V_LO[v]);
            chk($sformatf("R4 vec%0d ch1 lo", v), lc[1], V_PER[v]);
            chk($sformatf("R4 vec%0d ch2 hi", v), hc[2], V_PER[v]);
            chk($sformatf("R6 vec%0d overlap", v), ovl, 0);
        end

        // R3: count peaks at reload in center mode
        setup(1, 0, 0, 8, 3, 1);
        mx = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R3 center peak", mx, 8);

        // R1: divider of 4, edge mode reload 4, compare 2, dead 1
        setup(0, 0, 3, 4, 2, 1);
        repeat (80) @(negedge clk);
        tr = 0;
        mv = int'(count);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(count) != mv) tr++;
            mv = int'(count);
        end
        chk("R1 count steps per 20 cycles", tr, 5);
        measure(20);
        chk("R1 divided ch0 hi", hc[0], 4);
        chk("R1 divided ch0 lo", lc[0], 8);

        // R8: halt mid-run
        setup(0, 0, 0, 9, 4, 2);
        repeat (40) @(negedge clk);
        dbg_halt = 1'b1;
        #1;
        chk("R8 outputs low same cycle", int'({pwm_hi, pwm_lo}), 0);
        c0 = int'(count);
        z = 0; mv = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if ({pwm_hi, pwm_lo} != 6'd0) z++;
            if (int'(count) != c0) mv++;
        end
        chk("R8 outputs during halt", z, 0);
        chk("R8 count moves during halt", mv, 0);
        dbg_halt = 1'b0;
        repeat (40) @(negedge clk);
        measure(10);
        chk("R8 resumes ch0 hi", hc[0], 2);
        chk("R8 resumes ch0 lo", lc[0], 4);

        // R9: reload written mid-period
        setup(0, 0, 0, 9, 4, 2);
        repeat (25) @(negedge clk);
        while (count != 16'd3) @(negedge clk);
        reload = 16'd19;
        mx = 3;
        @(negedge clk);
        while (count != 16'd0) begin
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        chk("R9 old limit ends current period", mx, 9);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R9 new limit next period", mx, 19);

        // R10: disable while running
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 count after disable", int'(count), 0);
        chk("R10 outputs after disable", int'({pwm_hi, pwm_lo}), 0);

        // R7: one-shot, reload 5, compare 3, dead 1
        setup(0, 1, 0, 5, 3, 1);
        measure(30);
        chk("R7 one-shot ch0 hi", hc[0], 2);
        chk("R7 one-shot ch0 lo", lc[0], 2);
        chk("R7 one-shot ch1 lo", lc[1], 5);
        chk("R7 one-shot ch2 hi", hc[2], 5);
        chk("R7 parked count", int'(count), 0);
        chk("R7 parked outputs", int'({pwm_hi, pwm_lo}), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule